// File: doc/BRIEF.md
# Forwarding and Interlock Control for a Five-Stage Pipeline

This block decides, cycle by cycle, where each operand of an in-order five-stage integer pipeline comes from and when the front of the pipeline must wait. It watches the register numbers that the decode and execute instructions read. It also watches the destination numbers and write flags held in the two pipeline registers after execute. From these it picks the data source for both ALU operands, for the two operands of a branch comparator that sits in decode, and for the data of a store in the memory stage. Only read-after-write dependencies are checked. Every instruction reads in decode and writes in write-back, so the other two orderings cannot arise.

When forwarding cannot hide a dependency, the unit raises a stall that holds the PC and the fetch/decode register. In the same cycle it raises a bubble that clears the control fields entering execute. A load followed by a dependent instruction costs one such cycle. A store whose data comes from the load just ahead of it costs none: the loaded word is steered into the store data at the memory stage. A branch costs one cycle behind an ALU producer and two behind a load producer. The unit keeps a single flag of its own, which records whether the instruction now in the execute/memory register is a load.

Top module: `fwd_interlock_unit`

## Requirements
- R1: Select codes are 2'b00 for the register file, 2'b01 for the memory/write-back register and 2'b10 for the execute/memory register. The code 2'b11 never appears. An ALU operand whose register matches a writing, non-load execute/memory destination gets 2'b10.
- R2: An operand that matches only a writing memory/write-back destination gets 2'b01 on the ALU, branch-compare or store-data select.
- R3: When both later registers write the operand's register, the execute/memory register wins (2'b10).
- R4: Register 0, or a producer whose write flag is low, never causes forwarding or a stall.
- R5: A non-store instruction in decode that reads the destination of a load in execute raises stall and bubble together for exactly that cycle.
- R6: A store in decode whose data register (second source) alone matches a load in execute does not stall. Once that store reaches memory, the store-data select (1 = write-back value) goes high when its data register matches a writing write-back destination.
- R7: A load held in the execute/memory register is never the source of an operand select of 2'b10.
- R8: A branch in decode reading the destination of a non-load in execute stalls one cycle, then takes that value with a compare select of 2'b10.
- R9: A branch reading the destination of a load in execute stalls two cycles, then takes the value with a compare select of 2'b01.
- R10: During reset and in the first cycle after it, no load is assumed to sit in the execute/memory register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| id_rs1 | input | REG_W | First source of the decode instruction |
| id_rs2 | input | REG_W | Second source of the decode instruction (store data for stores) |
| id_is_branch | input | 1 | Decode instruction is a branch compared in decode |
| id_is_store | input | 1 | Decode instruction is a store |
| ex_rs1 | input | REG_W | First source of the execute instruction |
| ex_rs2 | input | REG_W | Second source of the execute instruction |
| ex_rd | input | REG_W | Destination of the execute instruction |
| ex_we | input | 1 | Execute instruction writes a register |
| ex_is_load | input | 1 | Execute instruction is a load |
| exm_rd | input | REG_W | Destination in the execute/memory register |
| exm_we | input | 1 | Write flag in the execute/memory register |
| mwb_rd | input | REG_W | Destination in the memory/write-back register |
| mwb_we | input | 1 | Write flag in the memory/write-back register |
| mem_is_store | input | 1 | Memory-stage instruction is a store |
| mem_st_src | input | REG_W | Data register of the memory-stage store |
| fwd_a | output | 2 | First ALU operand select |
| fwd_b | output | 2 | Second ALU operand select |
| fwd_cmp_a | output | 2 | First branch-compare operand select |
| fwd_cmp_b | output | 2 | Second branch-compare operand select |
| fwd_st | output | 1 | Store data taken from the write-back value |
| stall | output | 1 | Hold PC and fetch/decode register |
| bubble | output | 1 | Clear control entering execute |

## Verification
A long pseudo-random sweep draws every register field from the four lowest register numbers and every flag at random. This keeps matches, mismatches and register 0 all frequent, and it exercises priority between the two later registers, write-flag-low producers and the store exemption against an arithmetic model. Directed sequences step a load-use pair, a load feeding a store and both branch cases through real clock edges. They tell a one-cycle interlock apart from a two-cycle one, and they show the source the operand takes once the stall ends. A check right after reset separates a fresh start from a stale load flag.

// File: rtl/hazard_pkg.sv
package hazard_pkg;
  typedef enum logic [1:0] {
    SEL_REGFILE = 2'b00,
    SEL_LATE    = 2'b01,
    SEL_EARLY   = 2'b10
  } fwd_sel_e;
endpackage

// File: rtl/fwd_pick.sv
module fwd_pick
  import hazard_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [REG_W-1:0] src,
  input  logic [REG_W-1:0] early_rd,
  input  logic             early_ok,
  input  logic [REG_W-1:0] late_rd,
  input  logic             late_ok,
  output logic [1:0]       sel
);
  logic     hit_early, hit_late;
  fwd_sel_e pick;

  always_comb begin
    hit_early = early_ok && (early_rd != '0) && (early_rd == src);
    hit_late  = late_ok  && (late_rd  != '0) && (late_rd  == src);
    if (hit_early)     pick = SEL_EARLY;
    else if (hit_late) pick = SEL_LATE;
    else               pick = SEL_REGFILE;
  end

  assign sel = pick;

  p_code_legal_r1: assert property (@(posedge clk) disable iff (rst)
    sel != 2'b11);
  p_zero_src_r4: assert property (@(posedge clk) disable iff (rst)
    (src == '0) |-> (sel == 2'b00));
  p_early_wins_r3: assert property (@(posedge clk) disable iff (rst)
    (early_ok && late_ok && src != '0 && early_rd == src && late_rd == src)
      |-> (sel == 2'b10));
endmodule

// File: rtl/interlock_ctl.sv
module interlock_ctl #(
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [REG_W-1:0] id_rs1,
  input  logic [REG_W-1:0] id_rs2,
  input  logic             id_is_branch,
  input  logic             id_is_store,
  input  logic [REG_W-1:0] ex_rd,
  input  logic             ex_we,
  input  logic             ex_is_load,
  input  logic [REG_W-1:0] exm_rd,
  input  logic             exm_we,
  output logic             exm_is_load,
  output logic             stall
);
  logic exm_ld_q;
  logic ex_live, exm_live;
  logic hit_ex_rs1, hit_ex_rs2, hit_exm_rs1, hit_exm_rs2;
  logic load_use, branch_wait;

  // tracks whether the execute/memory register holds a load (R10)
  always_ff @(posedge clk) begin
    if (rst) exm_ld_q <= 1'b0;
    else     exm_ld_q <= ex_is_load;
  end
  assign exm_is_load = exm_ld_q;

  always_comb begin
    ex_live     = ex_we && (ex_rd != '0);
    exm_live    = exm_we && (exm_rd != '0);
    hit_ex_rs1  = ex_live && (ex_rd == id_rs1);
    hit_ex_rs2  = ex_live && (ex_rd == id_rs2);
    hit_exm_rs1 = exm_live && (exm_rd == id_rs1);
    hit_exm_rs2 = exm_live && (exm_rd == id_rs2);
    // store data may wait for the memory-stage path, base register may not
    load_use    = ex_is_load &&
                  (hit_ex_rs1 || (hit_ex_rs2 && !(id_is_store && !id_is_branch)));
    branch_wait = id_is_branch &&
                  (hit_ex_rs1 || hit_ex_rs2 ||
                   (exm_ld_q && (hit_exm_rs1 || hit_exm_rs2)));
    stall       = load_use || branch_wait;
  end

  p_no_reg_no_stall_r4: assert property (@(posedge clk) disable iff (rst)
    (id_rs1 == '0 && id_rs2 == '0) |-> !stall);
  p_load_use_r5: assert property (@(posedge clk) disable iff (rst)
    (ex_is_load && ex_we && ex_rd != '0 && ex_rd == id_rs1) |-> stall);
  p_store_pass_r6: assert property (@(posedge clk) disable iff (rst)
    (id_is_store && !id_is_branch && ex_is_load && ex_rd == id_rs2 &&
     ex_rd != id_rs1 && !exm_ld_q) |-> !stall);
  p_branch_two_r9: assert property (@(posedge clk) disable iff (rst)
    (id_is_branch && ex_is_load && ex_we && ex_rd != '0 && ex_rd == id_rs1) ##1
    (id_is_branch && $stable(id_rs1) && exm_we && exm_rd == $past(ex_rd))
      |-> stall);
endmodule

// File: rtl/st_data_fwd.sv
module st_data_fwd #(
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mem_is_store,
  input  logic [REG_W-1:0] mem_st_src,
  input  logic [REG_W-1:0] mwb_rd,
  input  logic             mwb_we,
  output logic             fwd_st
);
  always_comb
    fwd_st = mem_is_store && mwb_we && (mwb_rd != '0) && (mwb_rd == mem_st_src);

  p_st_needs_writer_r6: assert property (@(posedge clk) disable iff (rst)
    fwd_st |-> (mwb_we && mem_is_store));
  p_st_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (mem_st_src == '0) |-> !fwd_st);
endmodule

// File: rtl/fwd_interlock_unit.sv
module fwd_interlock_unit #(
  parameter int NREGS = 32,
  localparam int REG_W = $clog2(NREGS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [REG_W-1:0] id_rs1,
  input  logic [REG_W-1:0] id_rs2,
  input  logic             id_is_branch,
  input  logic             id_is_store,
  input  logic [REG_W-1:0] ex_rs1,
  input  logic [REG_W-1:0] ex_rs2,
  input  logic [REG_W-1:0] ex_rd,
  input  logic             ex_we,
  input  logic             ex_is_load,
  input  logic [REG_W-1:0] exm_rd,
  input  logic             exm_we,
  input  logic [REG_W-1:0] mwb_rd,
  input  logic             mwb_we,
  input  logic             mem_is_store,
  input  logic [REG_W-1:0] mem_st_src,
  output logic [1:0]       fwd_a,
  output logic [1:0]       fwd_b,
  output logic [1:0]       fwd_cmp_a,
  output logic [1:0]       fwd_cmp_b,
  output logic             fwd_st,
  output logic             stall,
  output logic             bubble
);
  localparam int NPICK = 4;

  logic             exm_is_load;
  logic             exm_ok;
  logic [REG_W-1:0] pick_src [NPICK];
  logic [1:0]       pick_sel [NPICK];

  // a load's address in execute/memory is never a forwardable result (R7)
  assign exm_ok = exm_we && !exm_is_load;

  assign pick_src[0] = ex_rs1;
  assign pick_src[1] = ex_rs2;
  assign pick_src[2] = id_rs1;
  assign pick_src[3] = id_rs2;

  for (genvar g = 0; g < NPICK; g++) begin : g_pick
    fwd_pick #(.REG_W(REG_W)) u_pick (
      .clk      (clk),
      .rst      (rst),
      .src      (pick_src[g]),
      .early_rd (exm_rd),
      .early_ok (exm_ok),
      .late_rd  (mwb_rd),
      .late_ok  (mwb_we),
      .sel      (pick_sel[g])
    );
  end

  assign fwd_a     = pick_sel[0];
  assign fwd_b     = pick_sel[1];
  assign fwd_cmp_a = pick_sel[2];
  assign fwd_cmp_b = pick_sel[3];

  interlock_ctl #(.REG_W(REG_W)) u_ilk (
    .clk          (clk),
    .rst          (rst),
    .id_rs1       (id_rs1),
    .id_rs2       (id_rs2),
    .id_is_branch (id_is_branch),
    .id_is_store  (id_is_store),
    .ex_rd        (ex_rd),
    .ex_we        (ex_we),
    .ex_is_load   (ex_is_load),
    .exm_rd       (exm_rd),
    .exm_we       (exm_we),
    .exm_is_load  (exm_is_load),
    .stall        (stall)
  );

  st_data_fwd #(.REG_W(REG_W)) u_st (
    .clk          (clk),
    .rst          (rst),
    .mem_is_store (mem_is_store),
    .mem_st_src   (mem_st_src),
    .mwb_rd       (mwb_rd),
    .mwb_we       (mwb_we),
    .fwd_st       (fwd_st)
  );

  assign bubble = stall;

  p_no_load_fwd_r7: assert property (@(posedge clk) disable iff (rst)
    exm_is_load |-> (fwd_a != 2'b10 && fwd_b != 2'b10 &&
                     fwd_cmp_a != 2'b10 && fwd_cmp_b != 2'b10));
  p_branch_alu_r8: assert property (@(posedge clk) disable iff (rst)
    (id_is_branch && !ex_is_load && ex_we && ex_rd != '0 && ex_rd == id_rs1) ##1
    (id_is_branch && $stable(id_rs1) && exm_we && exm_rd == $past(ex_rd) && !stall)
      |-> (fwd_cmp_a == 2'b10));
endmodule

// File: tb/fwd_interlock_unit_tb.sv
module fwd_interlock_unit_tb;
  localparam int NREGS = 32;
  localparam int RW = $clog2(NREGS);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [RW-1:0] id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, exm_rd, mwb_rd, mem_st_src;
  logic id_is_branch, id_is_store, ex_we, ex_is_load, exm_we, mwb_we, mem_is_store;
  logic [1:0] fwd_a, fwd_b, fwd_cmp_a, fwd_cmp_b;
  logic fwd_st, stall, bubble;

  int checks = 0;
  int errors = 0;
  logic ld_prev = 1'b0;
  logic [31:0] seed = 32'h1234_5678;

  always #5 clk = ~clk;

  fwd_interlock_unit #(.NREGS(NREGS)) u_dut (.*);

  // model of the execute/memory load flag: last cycle's execute load (R10)
  always_ff @(posedge clk) ld_prev <= rst ? 1'b0 : ex_is_load;

  function automatic logic [1:0] want_sel(input logic [RW-1:0] s);
    logic okm, okw;
    okm = exm_we && exm_rd != 0 && !ld_prev;   // R7
    okw = mwb_we && mwb_rd != 0;               // R4
    if (okm && exm_rd == s) return 2'b10;      // R1, R3
    if (okw && mwb_rd == s) return 2'b01;      // R2
    return 2'b00;
  endfunction

  function automatic logic want_stall();
    logic exl, h1, h2, m1, m2, lu, br;
    exl = ex_we && ex_rd != 0;
    h1 = exl && ex_rd == id_rs1;
    h2 = exl && ex_rd == id_rs2;
    m1 = exm_we && exm_rd != 0 && exm_rd == id_rs1;
    m2 = exm_we && exm_rd != 0 && exm_rd == id_rs2;
    lu = ex_is_load && (h1 || (h2 && !(id_is_store && !id_is_branch)));   // R5, R6
    br = id_is_branch && (h1 || h2 || (ld_prev && (m1 || m2)));          // R8, R9
    return lu || br;
  endfunction

  task automatic chk2(input string tag, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    chk2({tag, " R1 fwd_a"}, fwd_a, want_sel(ex_rs1));
    chk2({tag, " R2 fwd_b"}, fwd_b, want_sel(ex_rs2));
    chk2({tag, " R8 cmp_a"}, fwd_cmp_a, want_sel(id_rs1));
    chk2({tag, " R9 cmp_b"}, fwd_cmp_b, want_sel(id_rs2));
    chk2({tag, " R6 fwd_st"}, {1'b0, fwd_st},
         {1'b0, mem_is_store && mwb_we && mwb_rd != 0 && mwb_rd == mem_st_src});
    chk2({tag, " R5 stall"}, {bubble, stall}, {want_stall(), want_stall()});
  endtask

  task automatic idle();
    {id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, exm_rd, mwb_rd, mem_st_src} = '0;
    {id_is_branch, id_is_store, ex_we, ex_is_load, exm_we, mwb_we, mem_is_store} = '0;
  endtask

  function automatic logic [31:0] nxt(input logic [31:0] s);
    return s * 32'd1103515245 + 32'd12345;
  endfunction

  initial begin
    idle();
    repeat (3) @(negedge clk);
    // R10: reset clears the load flag even if a load sat in execute
    ex_is_load = 1'b1; ex_we = 1'b1; ex_rd = 5'd3;
    @(negedge clk);
    rst = 1'b0; ex_is_load = 1'b0; ex_we = 1'b0; ex_rd = '0;
    id_is_branch = 1'b1; id_rs1 = 5'd3; exm_we = 1'b1; exm_rd = 5'd3;
    #1;
    chk2("R10 reset stall", {1'b0, stall}, 2'b00);
    chk2("R10 reset cmp_a", fwd_cmp_a, 2'b10);
    check_all("R10");

    // R5: load then dependent ALU op, one cycle only
    @(negedge clk); idle();
    ex_is_load = 1'b1; ex_we = 1'b1; ex_rd = 5'd7; id_rs1 = 5'd7;
    #1 chk2("R5 load-use stall", {bubble, stall}, 2'b11);
    @(negedge clk); idle();
    exm_we = 1'b1; exm_rd = 5'd7; ex_rs1 = 5'd7; ex_we = 1'b0;
    #1 chk2("R5 after bubble", {bubble, stall}, 2'b00);
    chk2("R7 no early fwd of load", fwd_a, 2'b00);
    @(negedge clk); idle();
    mwb_we = 1'b1; mwb_rd = 5'd7; ex_rs1 = 5'd7;
    #1 chk2("R2 late fwd", fwd_a, 2'b01);

    // R6: load feeding store data
    @(negedge clk); idle();
    ex_is_load = 1'b1; ex_we = 1'b1; ex_rd = 5'd9;
    id_is_store = 1'b1; id_rs1 = 5'd2; id_rs2 = 5'd9;
    #1 chk2("R6 store no stall", {bubble, stall}, 2'b00);
    @(negedge clk); idle();
    mwb_we = 1'b1; mwb_rd = 5'd9; mem_is_store = 1'b1; mem_st_src = 5'd9;
    #1 chk2("R6 store data fwd", {1'b0, fwd_st}, 2'b01);

    // R8: branch after ALU producer
    @(negedge clk); idle();
    id_is_branch = 1'b1; id_rs2 = 5'd4; ex_we = 1'b1; ex_rd = 5'd4;
    #1 chk2("R8 stall 1", {1'b0, stall}, 2'b01);
    @(negedge clk);
    ex_we = 1'b0; ex_rd = '0; exm_we = 1'b1; exm_rd = 5'd4;
    #1 chk2("R8 released", {1'b0, stall}, 2'b00);
    chk2("R8 cmp early", fwd_cmp_b, 2'b10);

    // R9: branch after load producer
    @(negedge clk); idle();
    id_is_branch = 1'b1; id_rs1 = 5'd6; ex_is_load = 1'b1; ex_we = 1'b1; ex_rd = 5'd6;
    #1 chk2("R9 stall 1", {1'b0, stall}, 2'b01);
    @(negedge clk);
    ex_is_load = 1'b0; ex_we = 1'b0; ex_rd = '0; exm_we = 1'b1; exm_rd = 5'd6;
    #1 chk2("R9 stall 2", {1'b0, stall}, 2'b01);
    @(negedge clk);
    exm_we = 1'b0; exm_rd = '0; mwb_we = 1'b1; mwb_rd = 5'd6;
    #1 chk2("R9 released", {1'b0, stall}, 2'b00);
    chk2("R9 cmp late", fwd_cmp_a, 2'b01);

    // R3 and R4 directed
    @(negedge clk); idle();
    ex_rs2 = 5'd5; exm_we = 1'b1; exm_rd = 5'd5; mwb_we = 1'b1; mwb_rd = 5'd5;
    #1 chk2("R3 priority", fwd_b, 2'b10);
    @(negedge clk); idle();
    ex_rs1 = 5'd0; exm_we = 1'b1; exm_rd = 5'd0; ex_rs2 = 5'd8; mwb_we = 1'b0; mwb_rd = 5'd8;
    #1 chk2("R4 zero reg", fwd_a, 2'b00);
    chk2("R4 we low", fwd_b, 2'b00);

    // near-exhaustive sweep over registers 0..3 and all flags
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      seed = nxt(seed);
      {id_rs1, id_rs2, ex_rs1, ex_rs2} = {3'b0, seed[1:0], 3'b0, seed[3:2],
                                          3'b0, seed[5:4], 3'b0, seed[7:6]};
      {ex_rd, exm_rd, mwb_rd, mem_st_src} = {3'b0, seed[9:8], 3'b0, seed[11:10],
                                             3'b0, seed[13:12], 3'b0, seed[15:14]};
      {id_is_branch, id_is_store, ex_we, ex_is_load} = seed[19:16];
      {exm_we, mwb_we, mem_is_store} = seed[22:20];
      #1 check_all("sweep");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule